// File: doc/BRIEF.md
# Banked Program Counter Sequencer

This block produces the 12-bit instruction fetch address for a small controller whose program space is made of two 2K-word halves. The instruction decoder presents one-cycle strobes (count, branch, subroutine entry, return, return that also restores interrupt state, interrupt entry, the two half-select commands and a synchronous reset) together with an 11-bit branch destination and a 2-bit interrupt source code. Every change appears on the fetch address in the cycle after the clock edge that samples the strobes.

The upper address bit is never driven straight from a half-select command. A separate half-select flag is updated by those commands and is copied into bit 11 only when a branch or subroutine entry loads a new address. Counting stays inside the current half. Subroutine entry and interrupt entry save the complete 12-bit address on an eight-entry circular return stack, so that returns bring back the caller's half. While an interrupt handler runs, bit 11 of the fetch address reads as zero.

Top module: `pc_seq_top`

## Requirements
- R1: A cycle with `rst` high sets the fetch address to 000h, clears the half-select flag, leaves the interrupt state, sets the stack pointer to 0 and clears all eight stack entries to 000h.
- R2: A count strobe adds one to bits 10..0, wrapping from 7FFh to 000h, and leaves bit 11 unchanged.
- R3: `sel_hi` sets the half-select flag and `sel_lo` clears it; when both are high in one cycle the flag is cleared. Neither one changes the fetch address on its own.
- R4: A branch loads bits 10..0 from `target` and bit 11 from the half-select flag as it stood before that clock edge, so a select in the same cycle takes effect only at the next branch.
- R5: Subroutine entry writes the full 12-bit current address into the stack and then loads the address exactly as a branch does.
- R6: A plain return reloads all 12 bits from the most recently written stack entry and leaves the half-select flag as it was.
- R7: Interrupt entry writes the full current address into the stack, enters the handler state and loads 007h when `irq_src` is 2'b10, and 003h for every other code.
- R8: While in the handler state, bit 11 of `fetch_addr` reads 0 whatever was loaded; half-select commands still update the flag.
- R9: The restoring return reloads all 12 bits from the stack and leaves the handler state, so bit 11 is again the stored value.
- R10: The stack holds 8 entries addressed by a 3-bit pointer that wraps: the ninth write overwrites the oldest entry, and a return with nothing written reads entry 7.
- R11: With several strobes in one cycle, only one action is taken, in the order reset, interrupt entry, subroutine entry, branch, restoring return, plain return, count. Half-select commands act alongside any of these except reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cnt | input | 1 | Count strobe |
| br | input | 1 | Branch strobe |
| sub | input | 1 | Subroutine entry strobe |
| ret | input | 1 | Plain return strobe |
| ret_irq | input | 1 | Restoring return strobe that ends a handler |
| irq | input | 1 | Interrupt entry strobe |
| sel_lo | input | 1 | Clear the half-select flag |
| sel_hi | input | 1 | Set the half-select flag |
| target | input | 11 | Branch and subroutine destination, bits 10..0 |
| irq_src | input | 2 | Interrupt source code choosing the handler address |
| fetch_addr | output | 12 | Current instruction fetch address |

## Verification
The bench aims at the count wrap at 7FFh and FFFh, where a full 12-bit adder would carry into the other half. It issues a half-select in the same cycle as a branch, which catches a flag that is forwarded instead of registered, and selects inside a handler, where a design that drives bit 11 straight from the flag would leak a 1. It writes the stack nine times and returns with nothing written, so that a saturating or non-wrapping pointer returns the wrong address. It also fires every strobe together to expose a wrong priority order.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

    localparam int ADDR_W   = 12;
    localparam int OFF_W    = ADDR_W - 1;
    localparam int STK_DEPTH = 8;
    localparam int STK_PTR_W = $clog2(STK_DEPTH);

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_COUNT,
        OP_BRANCH,
        OP_SUB,
        OP_RET,
        OP_RET_IRQ,
        OP_IRQ
    } pc_op_e;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [OFF_W-1:0]  off_t;

    // Priority: interrupt, subroutine, branch, restoring return, return, count
    function automatic pc_op_e pick_op(
        input logic irq, input logic sub, input logic br,
        input logic ret_irq, input logic ret, input logic cnt);
        pc_op_e op;
        if (irq)          op = OP_IRQ;
        else if (sub)     op = OP_SUB;
        else if (br)      op = OP_BRANCH;
        else if (ret_irq) op = OP_RET_IRQ;
        else if (ret)     op = OP_RET;
        else if (cnt)     op = OP_COUNT;
        else              op = OP_HOLD;
        return op;
    endfunction

    // Handler address: 007h only for code 2'b10, otherwise 003h
    function automatic addr_t handler_addr(input logic [1:0] src);
        addr_t a;
        a = '0;
        a[1:0] = 2'b11;
        a[2]   = src[1] & ~src[0];
        return a;
    endfunction

    function automatic addr_t count_next(input addr_t pc);
        addr_t n;
        n[ADDR_W-1]  = pc[ADDR_W-1];
        n[OFF_W-1:0] = pc[OFF_W-1:0] + 1'b1;
        return n;
    endfunction

endpackage

// File: rtl/pc_half_flag.sv
module pc_half_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_hi,
    input  logic set_lo,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_lo)  flag <= 1'b0;
        else if (set_hi)  flag <= 1'b1;
    end

    AST_HI_SETS: assert property (@(posedge clk) disable iff (rst)
        (set_hi && !set_lo) |=> flag);                           // R3
    AST_LO_CLEARS: assert property (@(posedge clk) disable iff (rst)
        set_lo |=> !flag);                                       // R3
endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] top_data
);
    localparam int PW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    ptr;
    logic [PW-1:0]    top_idx;

    assign top_idx  = ptr - 1'b1;
    assign top_data = mem[top_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (push) begin
            ptr <= ptr + 1'b1;
        end else if (pop) begin
            ptr <= top_idx;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (push && ptr == PW'(g))
                mem[g] <= wr_data;
        end
    end

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        push |=> ptr == $past(ptr) + 1'b1);                      // R10
    AST_PTR_RETREAT: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> ptr == $past(ptr) - 1'b1);            // R10
    AST_PUSH_STORED: assert property (@(posedge clk) disable iff (rst)
        push |=> top_data == $past(wr_data));                    // R5
endmodule

// File: rtl/pc_counter.sv
module pc_counter
    import pc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pc_op_e     op,
    input  off_t       target,
    input  logic [1:0] irq_src,
    input  logic       half_flag,
    input  addr_t      stack_top,
    output addr_t      pc,
    output logic       in_handler
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc         <= '0;
            in_handler <= 1'b0;
        end else begin
            unique case (op)
                OP_COUNT:  pc <= count_next(pc);
                OP_BRANCH,
                OP_SUB:    pc <= {half_flag, target};
                OP_RET:    pc <= stack_top;
                OP_RET_IRQ: begin
                    pc         <= stack_top;
                    in_handler <= 1'b0;
                end
                OP_IRQ: begin
                    pc         <= handler_addr(irq_src);
                    in_handler <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    AST_COUNT_KEEPS_TOP: assert property (@(posedge clk) disable iff (rst)
        op == OP_COUNT |=> pc[ADDR_W-1] == $past(pc[ADDR_W-1]));      // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        op == OP_HOLD |=> $stable(pc));                               // R3
endmodule

// File: rtl/pc_seq_top.sv
module pc_seq_top
    import pc_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cnt,
    input  logic        br,
    input  logic        sub,
    input  logic        ret,
    input  logic        ret_irq,
    input  logic        irq,
    input  logic        sel_lo,
    input  logic        sel_hi,
    input  logic [10:0] target,
    input  logic [1:0]  irq_src,
    output logic [11:0] fetch_addr
);
    pc_op_e op;
    logic   half_flag;
    logic   in_handler;
    logic   push_en;
    logic   pop_en;
    addr_t  pc;
    addr_t  stack_top;

    assign op      = pick_op(irq, sub, br, ret_irq, ret, cnt);
    assign push_en = (op == OP_SUB) || (op == OP_IRQ);
    assign pop_en  = (op == OP_RET) || (op == OP_RET_IRQ);

    pc_half_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_hi (sel_hi),
        .set_lo (sel_lo),
        .flag   (half_flag)
    );

    pc_ret_stack #(
        .DEPTH (STK_DEPTH),
        .WIDTH (ADDR_W)
    ) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (push_en),
        .pop      (pop_en),
        .wr_data  (pc),
        .top_data (stack_top)
    );

    pc_counter u_pc (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .target     (target),
        .irq_src    (irq_src),
        .half_flag  (half_flag),
        .stack_top  (stack_top),
        .pc         (pc),
        .in_handler (in_handler)
    );

    // Bit 11 is masked while a handler runs
    assign fetch_addr = {pc[ADDR_W-1] & ~in_handler, pc[OFF_W-1:0]};

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> fetch_addr == '0);                                          // R1
    AST_BRANCH_LOAD: assert property (@(posedge clk) disable iff (rst)
        (br && !irq && !sub) |=> pc == {$past(half_flag), $past(target)});  // R4
    AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (rst)
        irq |=> fetch_addr[11:3] == '0 && fetch_addr[1:0] == 2'b11);        // R7
    AST_HANDLER_LOW: assert property (@(posedge clk) disable iff (rst)
        (irq || (in_handler && !ret_irq)) |=> fetch_addr[11] == 1'b0);      // R8
    AST_RET_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (pop_en && !sel_lo && !sel_hi) |=> half_flag == $past(half_flag));  // R6
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
        !(push_en && pop_en));                                              // R11
endmodule

// File: tb/tb_pc_seq_top.sv
module tb_pc_seq_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst, cnt, br, sub, ret, ret_irq, irq, sel_lo, sel_hi;
    logic [10:0] target;
    logic [1:0]  irq_src;
    logic [11:0] fetch_addr;

    int total = 0;
    int bad   = 0;

    // Reference model state
    logic [11:0] m_pc;
    logic        m_flag;
    logic        m_hnd;
    logic [11:0] m_stk [8];
    logic [2:0]  m_ptr;

    always #(CLK_P/2) clk = ~clk;

    pc_seq_top dut (
        .clk(clk), .rst(rst), .cnt(cnt), .br(br), .sub(sub), .ret(ret),
        .ret_irq(ret_irq), .irq(irq), .sel_lo(sel_lo), .sel_hi(sel_hi),
        .target(target), .irq_src(irq_src), .fetch_addr(fetch_addr)
    );

    function automatic logic [11:0] exp_vector(input logic [1:0] s);
        return (s == 2'b10) ? 12'h007 : 12'h003;
    endfunction

    function automatic logic [11:0] exp_fetch();
        return {m_pc[11] & ~m_hnd, m_pc[10:0]};
    endfunction

    function automatic string tag_now();
        int n;
        n = int'(irq) + int'(sub) + int'(br) + int'(ret_irq) + int'(ret) + int'(cnt);
        if (rst)            return "R1";
        if (n > 1)          return "R11";
        if (irq)            return "R7";
        if (sub)            return "R5";
        if (br)             return "R4";
        if (ret_irq)        return "R9";
        if (ret)            return "R6";
        if (cnt)            return "R2";
        if (m_hnd)          return "R8";
        return "R3";
    endfunction

    task automatic model_update();
        logic [11:0] top;
        logic        old_flag;
        old_flag = m_flag;
        top      = m_stk[m_ptr - 3'd1];
        if (rst) begin
            m_pc = '0; m_flag = 1'b0; m_hnd = 1'b0; m_ptr = '0;
            for (int i = 0; i < 8; i++) m_stk[i] = '0;
        end else begin
            if (sel_lo)      m_flag = 1'b0;
            else if (sel_hi) m_flag = 1'b1;
            if (irq) begin
                m_stk[m_ptr] = m_pc; m_ptr = m_ptr + 3'd1;
                m_pc = exp_vector(irq_src); m_hnd = 1'b1;
            end else if (sub) begin
                m_stk[m_ptr] = m_pc; m_ptr = m_ptr + 3'd1;
                m_pc = {old_flag, target};
            end else if (br) begin
                m_pc = {old_flag, target};
            end else if (ret_irq) begin
                m_ptr = m_ptr - 3'd1; m_pc = top; m_hnd = 1'b0;
            end else if (ret) begin
                m_ptr = m_ptr - 3'd1; m_pc = top;
            end else if (cnt) begin
                m_pc[10:0] = m_pc[10:0] + 11'd1;
            end
        end
    endtask

    task automatic clear_in();
        rst = 0; cnt = 0; br = 0; sub = 0; ret = 0; ret_irq = 0; irq = 0;
        sel_lo = 0; sel_hi = 0; target = '0; irq_src = '0;
    endtask

    // Inputs are set at the falling edge; sample at the next falling edge
    task automatic tick();
        string t;
        t = tag_now();
        @(posedge clk);
        model_update();
        @(negedge clk);
        total++;
        if (fetch_addr !== exp_fetch()) begin
            bad++;
            $display("FAIL %s: fetch_addr=%03h expected=%03h", t, fetch_addr, exp_fetch());
        end
        clear_in();
    endtask

    task automatic do_branch(input logic [10:0] t);
        br = 1; target = t; tick();
    endtask

    initial begin
        #(CLK_P * 200000);
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        clear_in();
        m_pc = '0; m_flag = 0; m_hnd = 0; m_ptr = '0;
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
        @(negedge clk);
        rst = 1; tick();                 // R1 reset state
        rst = 1; tick();

        // R2 count wrap in lower half
        do_branch(11'h7FE);
        cnt = 1; tick();
        cnt = 1; tick();                 // 7FF -> 000
        // R3 select alone does not move the address
        sel_hi = 1; tick();
        // R4 branch picks up the flag
        do_branch(11'h100);              // expect 900
        do_branch(11'h7FF);              // FFF
        cnt = 1; tick();                 // R2 wrap stays in upper half: 800
        // R4 select in same cycle as branch uses old flag
        sel_lo = 1; br = 1; target = 11'h055; tick();   // 855
        do_branch(11'h055);              // now 055
        // R3 both selects: cleared
        sel_hi = 1; sel_lo = 1; tick();
        do_branch(11'h020);              // 020
        // R5 / R6 call into upper half and return
        sel_hi = 1; tick();
        sub = 1; target = 11'h321; tick();   // B21
        sel_lo = 1; ret = 1; tick();         // R6 back to 020
        do_branch(11'h010);                  // flag now 0 -> 010
        // R7 interrupt vectors
        sel_hi = 1; do_branch(11'h400);      // flag old 0 -> 400; flag now 1
        do_branch(11'h400);                  // C00
        irq = 1; irq_src = 2'b10; tick();    // 007
        // R8 branch in handler with flag set: bit 11 reads 0
        do_branch(11'h200);
        sel_hi = 1; tick();
        cnt = 1; tick();
        ret_irq = 1; tick();                 // R9 back to C00
        irq = 1; irq_src = 2'b01; tick();    // 003
        irq = 1; irq_src = 2'b11; tick();    // nested, 003
        ret_irq = 1; tick();
        ret_irq = 1; tick();
        irq = 1; irq_src = 2'b00; tick();
        ret_irq = 1; tick();
        // R10 nine writes, then nine returns
        for (int i = 0; i < 9; i++) begin
            sub = 1; target = 11'(i * 16 + 1); tick();
        end
        for (int i = 0; i < 9; i++) begin
            ret = 1; tick();
        end
        // R10 return from reset state reads entry 7
        rst = 1; tick();
        ret = 1; tick();
        // R11 all strobes together
        cnt = 1; br = 1; sub = 1; ret = 1; ret_irq = 1; irq = 1;
        irq_src = 2'b10; target = 11'h5A5; tick();
        sub = 1; br = 1; ret = 1; cnt = 1; target = 11'h0F0; tick();
        ret_irq = 1; ret = 1; cnt = 1; tick();
        rst = 1; irq = 1; sub = 1; sel_hi = 1; tick();  // R1 wins

        // Constrained random mix
        for (int k = 0; k < 4000; k++) begin
            rst     = ($urandom_range(199) == 0);
            cnt     = ($urandom_range(99) < 50);
            br      = ($urandom_range(99) < 8);
            sub     = ($urandom_range(99) < 8);
            ret     = ($urandom_range(99) < 8);
            ret_irq = ($urandom_range(99) < 4);
            irq     = ($urandom_range(99) < 4);
            sel_lo  = ($urandom_range(99) < 6);
            sel_hi  = ($urandom_range(99) < 6);
            target  = 11'($urandom);
            irq_src = 2'($urandom);
            tick();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule